// File: doc/BRIEF.md
# Trace Start/Stop Trigger Controller

This block decides, cycle by cycle, whether instruction trace collection is running for a simple in-order CPU. It receives the core's retire events: the retiring PC, a load or store flag with its effective address, a taken exception with its identifier, flags for return-from-exception, wait and halt instructions, and one external trigger level. It sets the trace-enable output accordingly. While trace is enabled, every retiring instruction produces a capture strobe. The strobe carries a programmable number of PC bits, starting at bit 1.

The start and stop conditions are configured separately. Each has its own condition selector and its own data and mask values. A programmable cycle delay can postpone the start edge, the stop edge or both. Manual start and stop strobes work in every mode. An init strobe loads a new configuration and returns the block to idle. A two-bit status output shows whether the block is idle, waiting to start, running, or waiting to stop.

Top module: `trace_gate`

## Requirements
- R1: After reset, `state_o` is 0, `trace_on` is 0 and `cap_valid` is 0. The reset configuration has both selectors at 0, no delay, and a capture width of XLEN-1 bits.
- R2: Selector codes 1, 2, 3 and 4 fire on the PC, the load address, the store address and the exception identifier respectively, when `(value & mask) == (data & mask)`.
  - Codes 1, 2 and 3 require `ret_valid`.
  - Codes 2 and 3 also require `ret_load` or `ret_store`, and they compare `ret_ea`, not the PC.
  - Code 4 requires `exc_valid` and compares the low EID_W bits of data and mask.
- R3: Selector codes 5 (return-from-exception), 6 (wait) and 7 (halt) fire in any cycle where `ret_valid` is high together with the matching flag, whatever the data and mask hold.
- R4: Start codes 8 and 9 fire while `ext_trig` is 1 or 0 respectively, with no retire needed. For the stop selector, codes 8 and 9 never fire, and neither does any other code above 9.
- R5: Selector code 0 never fires, so collection then follows only `man_start` and `man_stop`. Either strobe takes effect on the next clock edge.
- R6: Only the start condition is evaluated in state 0 (idle), and only the stop condition in state 2 (running). No condition is evaluated in states 1 (arming) and 3 (draining).
- R7: Delay mode encoding is 0 none, 1 start, 2 stop, 3 both.
  - A delayed edge with count N > 0 takes effect N cycles later than the undelayed one, passing through state 1 or 3 meanwhile.
  - A count of 0 acts as no delay.
- R8: Manual strobes cancel a pending delay. `man_stop` has priority over `man_start`, and both have priority over a trigger or a delay expiring in the same cycle.
- R9: `cfg_load` has priority over everything else. It latches all `cfg_*` inputs, returns the state to 0 and clears the delay counter. Events in that same cycle are ignored.
- R10: `state_o` reports 0 idle, 1 arming, 2 running, 3 draining. `trace_on` is high in states 2 and 3.
- R11: `cap_valid` is `trace_on && ret_valid`, combinationally. `cap_word` holds `ret_pc[P:1]` zero-extended, where P is the latched width; a latched width of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Init strobe: latch configuration, go idle |
| cfg_start_sel | input | 4 | Start condition code |
| cfg_stop_sel | input | 4 | Stop condition code |
| cfg_start_data | input | XLEN | Start compare data |
| cfg_start_mask | input | XLEN | Start compare mask |
| cfg_stop_data | input | XLEN | Stop compare data |
| cfg_stop_mask | input | XLEN | Stop compare mask |
| cfg_dly_mode | input | 2 | Delay mode |
| cfg_dly_cycles | input | DLY_W | Delay length in cycles |
| cfg_pc_bits | input | clog2(XLEN) | Captured PC bit count |
| man_start | input | 1 | Manual start strobe |
| man_stop | input | 1 | Manual stop strobe |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_load | input | 1 | Retiring instruction is a load |
| ret_store | input | 1 | Retiring instruction is a store |
| ret_ea | input | XLEN | Effective address of the load or store |
| exc_valid | input | 1 | An exception is taken |
| exc_id | input | EID_W | Exception identifier |
| ret_eret | input | 1 | Retiring instruction returns from exception |
| ret_wait | input | 1 | Retiring instruction is a wait |
| ret_halt | input | 1 | Retiring instruction is a halt |
| ext_trig | input | 1 | External trigger level |
| trace_on | output | 1 | Trace collection enabled |
| cap_valid | output | 1 | Capture word valid |
| cap_word | output | XLEN-1 | Captured PC bits starting at bit 1 |
| state_o | output | 2 | Controller status |

## Verification
A delay that expires and a manual strobe can land in the same cycle, and the strobe must win. To provoke this, the bench arms a delayed start with a count of 3 and waits until the counter is about to expire. It then raises `man_stop` on that exact cycle and expects idle rather than running. The same collision is repeated with `man_start` and `man_stop` together during arming. Random stimulus also makes triggers, strobes and init pulses coincide. Every cycle is judged against a cycle model written from the requirements.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;
   typedef enum logic [1:0] {
      TG_IDLE   = 2'd0,
      TG_ARMING = 2'd1,
      TG_ON     = 2'd2,
      TG_DRAIN  = 2'd3
   } tg_state_e;

   localparam logic [3:0] SEL_NONE  = 4'd0;
   localparam logic [3:0] SEL_PC    = 4'd1;
   localparam logic [3:0] SEL_LOAD  = 4'd2;
   localparam logic [3:0] SEL_STORE = 4'd3;
   localparam logic [3:0] SEL_EXC   = 4'd4;
   localparam logic [3:0] SEL_ERET  = 4'd5;
   localparam logic [3:0] SEL_WAIT  = 4'd6;
   localparam logic [3:0] SEL_HALT  = 4'd7;
   localparam logic [3:0] SEL_EXT_H = 4'd8;
   localparam logic [3:0] SEL_EXT_L = 4'd9;

   localparam int DLY_ON_START = 0;
   localparam int DLY_ON_STOP  = 1;
endpackage

// File: rtl/tg_match.sv
module tg_match
   import trace_gate_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int EID_W     = 8,
   parameter bit ALLOW_EXT = 1'b1
) (
   input  logic [3:0]       sel,
   input  logic [XLEN-1:0]  data,
   input  logic [XLEN-1:0]  mask,
   input  logic             ret_valid,
   input  logic [XLEN-1:0]  ret_pc,
   input  logic             ret_load,
   input  logic             ret_store,
   input  logic [XLEN-1:0]  ret_ea,
   input  logic             exc_valid,
   input  logic [EID_W-1:0] exc_id,
   input  logic             ret_eret,
   input  logic             ret_wait,
   input  logic             ret_halt,
   input  logic             ext_trig,
   output logic             hit
);
   logic pc_eq, ea_eq, id_eq, ext_hit;

   assign pc_eq = ((ret_pc & mask) == (data & mask));
   assign ea_eq = ((ret_ea & mask) == (data & mask));
   assign id_eq = ((exc_id & mask[EID_W-1:0]) == (data[EID_W-1:0] & mask[EID_W-1:0]));

   generate
      if (ALLOW_EXT) begin : g_ext
         assign ext_hit = ((sel == SEL_EXT_H) && ext_trig) ||
                          ((sel == SEL_EXT_L) && !ext_trig);
      end else begin : g_no_ext
         assign ext_hit = ext_trig & 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_PC:    hit = ret_valid && pc_eq;
         SEL_LOAD:  hit = ret_valid && ret_load && ea_eq;
         SEL_STORE: hit = ret_valid && ret_store && ea_eq;
         SEL_EXC:   hit = exc_valid && id_eq;
         SEL_ERET:  hit = ret_valid && ret_eret;
         SEL_WAIT:  hit = ret_valid && ret_wait;
         SEL_HALT:  hit = ret_valid && ret_halt;
         SEL_EXT_H,
         SEL_EXT_L: hit = ext_hit;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/tg_delay.sv
module tg_delay #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [DLY_W-1:0] ld_val,
   output logic             expire
);
   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (ld)           cnt <= ld_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == DLY_W'(1));
endmodule

// File: rtl/trace_gate.sv
module trace_gate
   import trace_gate_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int EID_W = 8,
   parameter int DLY_W = 16,
   localparam int CAPW = XLEN - 1,
   localparam int PBW  = $clog2(XLEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [3:0]       cfg_start_sel,
   input  logic [3:0]       cfg_stop_sel,
   input  logic [XLEN-1:0]  cfg_start_data,
   input  logic [XLEN-1:0]  cfg_start_mask,
   input  logic [XLEN-1:0]  cfg_stop_data,
   input  logic [XLEN-1:0]  cfg_stop_mask,
   input  logic [1:0]       cfg_dly_mode,
   input  logic [DLY_W-1:0] cfg_dly_cycles,
   input  logic [PBW-1:0]   cfg_pc_bits,
   input  logic             man_start,
   input  logic             man_stop,
   input  logic             ret_valid,
   input  logic [XLEN-1:0]  ret_pc,
   input  logic             ret_load,
   input  logic             ret_store,
   input  logic [XLEN-1:0]  ret_ea,
   input  logic             exc_valid,
   input  logic [EID_W-1:0] exc_id,
   input  logic             ret_eret,
   input  logic             ret_wait,
   input  logic             ret_halt,
   input  logic             ext_trig,
   output logic             trace_on,
   output logic             cap_valid,
   output logic [CAPW-1:0]  cap_word,
   output logic [1:0]       state_o
);
   generate
      if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
         $error("trace_gate: XLEN must lie in 8..64");
      end
      if (EID_W < 1 || EID_W > XLEN) begin : g_bad_eid
         $error("trace_gate: EID_W must lie in 1..XLEN");
      end
      if (DLY_W < 2) begin : g_bad_dly
         $error("trace_gate: DLY_W must be at least 2");
      end
   endgenerate

   // latched configuration
   logic [3:0]       c_ssel, c_psel;
   logic [XLEN-1:0]  c_sdat, c_smsk, c_pdat, c_pmsk;
   logic [1:0]       c_dmode;
   logic [DLY_W-1:0] c_dcyc;
   logic [PBW-1:0]   c_pcb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_ssel  <= SEL_NONE;
         c_psel  <= SEL_NONE;
         c_sdat  <= '0;
         c_smsk  <= '0;
         c_pdat  <= '0;
         c_pmsk  <= '0;
         c_dmode <= '0;
         c_dcyc  <= '0;
         c_pcb   <= PBW'(CAPW);
      end else if (cfg_load) begin
         c_ssel  <= cfg_start_sel;
         c_psel  <= cfg_stop_sel;
         c_sdat  <= cfg_start_data;
         c_smsk  <= cfg_start_mask;
         c_pdat  <= cfg_stop_data;
         c_pmsk  <= cfg_stop_mask;
         c_dmode <= cfg_dly_mode;
         c_dcyc  <= cfg_dly_cycles;
         c_pcb   <= cfg_pc_bits;
      end
   end

   logic start_hit, stop_hit;

   tg_match #(.XLEN(XLEN), .EID_W(EID_W), .ALLOW_EXT(1'b1)) u_start (
      .sel(c_ssel), .data(c_sdat), .mask(c_smsk),
      .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_load(ret_load),
      .ret_store(ret_store), .ret_ea(ret_ea), .exc_valid(exc_valid),
      .exc_id(exc_id), .ret_eret(ret_eret), .ret_wait(ret_wait),
      .ret_halt(ret_halt), .ext_trig(ext_trig), .hit(start_hit)
   );

   tg_match #(.XLEN(XLEN), .EID_W(EID_W), .ALLOW_EXT(1'b0)) u_stop (
      .sel(c_psel), .data(c_pdat), .mask(c_pmsk),
      .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_load(ret_load),
      .ret_store(ret_store), .ret_ea(ret_ea), .exc_valid(exc_valid),
      .exc_id(exc_id), .ret_eret(ret_eret), .ret_wait(ret_wait),
      .ret_halt(ret_halt), .ext_trig(ext_trig), .hit(stop_hit)
   );

   tg_state_e st, st_n;
   logic      dly_ld, dly_clr, dly_done;
   logic      dly_start, dly_stop;

   assign dly_start = c_dmode[DLY_ON_START] && (c_dcyc != '0);
   assign dly_stop  = c_dmode[DLY_ON_STOP]  && (c_dcyc != '0);

   tg_delay #(.DLY_W(DLY_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .clr(dly_clr), .ld(dly_ld),
      .ld_val(c_dcyc), .expire(dly_done)
   );

   always_comb begin
      st_n    = st;
      dly_ld  = 1'b0;
      dly_clr = 1'b0;
      if (cfg_load) begin
         st_n    = TG_IDLE;
         dly_clr = 1'b1;
      end else if (man_stop) begin
         st_n    = TG_IDLE;
         dly_clr = 1'b1;
      end else if (man_start) begin
         st_n    = TG_ON;
         dly_clr = 1'b1;
      end else begin
         unique case (st)
            TG_IDLE: if (start_hit) begin
               st_n   = dly_start ? TG_ARMING : TG_ON;
               dly_ld = dly_start;
            end
            TG_ARMING: if (dly_done) st_n = TG_ON;
            TG_ON: if (stop_hit) begin
               st_n   = dly_stop ? TG_DRAIN : TG_IDLE;
               dly_ld = dly_stop;
            end
            TG_DRAIN: if (dly_done) st_n = TG_IDLE;
            default: st_n = TG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= TG_IDLE;
      else        st <= st_n;
   end

   // capture path
   logic [PBW-1:0]  pcb_eff;
   logic [CAPW-1:0] cap_msk;

   assign pcb_eff = (c_pcb == '0) ? PBW'(1) : c_pcb;

   always_comb begin
      for (int i = 0; i < CAPW; i++) begin
         cap_msk[i] = (PBW'(i) < pcb_eff);
      end
   end

   assign trace_on  = (st == TG_ON) || (st == TG_DRAIN);
   assign cap_valid = trace_on && ret_valid;
   assign cap_word  = ret_pc[XLEN-1:1] & cap_msk;
   assign state_o   = st;
endmodule

// File: rtl/trace_gate_chk.sv
module trace_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_load,
   input logic       man_start,
   input logic       man_stop,
   input logic       trace_on,
   input logic       cap_valid,
   input logic [1:0] state_o
);
   AST_INIT_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (state_o == 2'd0)); // R9

   AST_MSTOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (man_stop && !cfg_load) |=> (state_o == 2'd0 && !trace_on)); // R8

   AST_MSTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (man_start && !man_stop && !cfg_load) |=> (state_o == 2'd2)); // R5

   AST_CAP_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> trace_on); // R11

   AST_DRAIN_NOT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3) |=> (state_o != 2'd1)); // R10

   AST_ARM_NOT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1) |=> (state_o != 2'd3)); // R6
endmodule

bind trace_gate trace_gate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .man_start(man_start),
   .man_stop(man_stop), .trace_on(trace_on), .cap_valid(cap_valid),
   .state_o(state_o)
);

// File: tb/tb_trace_gate.sv
`timescale 1ns/1ps
module tb_trace_gate;
   localparam int XLEN = 32, EID_W = 8, DLY_W = 16, PBW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_load = 0, man_start = 0, man_stop = 0;
   logic [3:0] cfg_start_sel = 0, cfg_stop_sel = 0;
   logic [31:0] cfg_start_data = 0, cfg_start_mask = 0, cfg_stop_data = 0, cfg_stop_mask = 0;
   logic [1:0] cfg_dly_mode = 0;
   logic [15:0] cfg_dly_cycles = 0;
   logic [4:0] cfg_pc_bits = 0;
   logic ret_valid = 0, ret_load = 0, ret_store = 0, exc_valid = 0;
   logic ret_eret = 0, ret_wait = 0, ret_halt = 0, ext_trig = 0;
   logic [31:0] ret_pc = 0, ret_ea = 0;
   logic [7:0] exc_id = 0;
   logic trace_on, cap_valid;
   logic [30:0] cap_word;
   logic [1:0] state_o;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   trace_gate #(.XLEN(XLEN), .EID_W(EID_W), .DLY_W(DLY_W)) dut (.*);

   // cycle model built from the requirements
   int m_st = 0, m_cnt = 0;
   int m_ssel = 0, m_psel = 0, m_dmode = 0, m_dcyc = 0, m_pcb = 31;
   logic [31:0] m_sdat = 0, m_smsk = 0, m_pdat = 0, m_pmsk = 0;

   function automatic bit f_hit(int sel, logic [31:0] d, logic [31:0] m, bit ext_ok);
      case (sel)
         1: return ret_valid && ((ret_pc & m) == (d & m));          // R2
         2: return ret_valid && ret_load && ((ret_ea & m) == (d & m));
         3: return ret_valid && ret_store && ((ret_ea & m) == (d & m));
         4: return exc_valid && ((exc_id & m[7:0]) == (d[7:0] & m[7:0]));
         5: return ret_valid && ret_eret;                            // R3
         6: return ret_valid && ret_wait;
         7: return ret_valid && ret_halt;
         8: return ext_ok && ext_trig;                               // R4
         9: return ext_ok && !ext_trig;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [30:0] f_cap(logic [31:0] pc, int pcb);
      int w = (pcb == 0) ? 1 : pcb;
      logic [30:0] msk = '0;
      for (int i = 0; i < w; i++) msk[i] = 1'b1;
      return pc[31:1] & msk;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: predict, advance, compare
   task automatic tick();
      int ns = m_st, nc;
      bit ld = 0, clr = 0;
      if (cfg_load) begin ns = 0; clr = 1; end
      else if (man_stop) begin ns = 0; clr = 1; end
      else if (man_start) begin ns = 2; clr = 1; end
      else begin
         case (m_st)
            0: if (f_hit(m_ssel, m_sdat, m_smsk, 1)) begin
                  ld = m_dmode[0] && m_dcyc != 0; ns = ld ? 1 : 2;
               end
            1: if (m_cnt == 1) ns = 2;
            2: if (f_hit(m_psel, m_pdat, m_pmsk, 0)) begin
                  ld = m_dmode[1] && m_dcyc != 0; ns = ld ? 3 : 0;
               end
            default: if (m_cnt == 1) ns = 0;
         endcase
      end
      nc = clr ? 0 : ld ? m_dcyc : (m_cnt != 0 ? m_cnt - 1 : 0);
      @(posedge clk);
      if (cfg_load) begin
         m_ssel = cfg_start_sel; m_psel = cfg_stop_sel;
         m_sdat = cfg_start_data; m_smsk = cfg_start_mask;
         m_pdat = cfg_stop_data; m_pmsk = cfg_stop_mask;
         m_dmode = cfg_dly_mode; m_dcyc = cfg_dly_cycles; m_pcb = cfg_pc_bits;
      end
      m_st = ns; m_cnt = nc;
      @(negedge clk);
      chk("R10 state", state_o, m_st);
      chk("R10 trace_on", trace_on, m_st >= 2);
      chk("R11 cap_valid", cap_valid, (m_st >= 2) && ret_valid);
      if (cap_valid) chk("R11 cap_word", cap_word, f_cap(ret_pc, m_pcb));
   endtask

   task automatic quiet();
      {cfg_load, man_start, man_stop, ret_valid, ret_load, ret_store} = '0;
      {exc_valid, ret_eret, ret_wait, ret_halt} = '0;
   endtask

   task automatic load_cfg(int ss, int ps, logic [31:0] sd, logic [31:0] sm,
                           logic [31:0] pd, logic [31:0] pm, int dm, int dc, int pcb);
      quiet();
      cfg_start_sel = 4'(ss); cfg_stop_sel = 4'(ps);
      cfg_start_data = sd; cfg_start_mask = sm; cfg_stop_data = pd; cfg_stop_mask = pm;
      cfg_dly_mode = 2'(dm); cfg_dly_cycles = 16'(dc); cfg_pc_bits = 5'(pcb);
      cfg_load = 1; tick(); cfg_load = 0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_7a11));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      ret_valid = 1; ret_pc = 32'h1234;
      #0.1;
      chk("R1 state", state_o, 0);
      chk("R1 trace_on", trace_on, 0);
      chk("R1 cap_valid", cap_valid, 0);
      quiet();

      // R2 masked PC start, R7 start delay of 3
      load_cfg(1, 2, 32'h40, 32'hFFFF_FFF0, 32'h80, 32'hFFFF_FFFF, 1, 3, 4);
      ret_valid = 1; ret_pc = 32'h4C; tick(); quiet();
      chk("R2 pc masked hit arms", state_o, 1);
      tick(); tick();
      chk("R7 still arming", state_o, 1);
      tick();
      chk("R7 running after 3", state_o, 2);
      // R11 capture width 4
      ret_valid = 1; ret_pc = 32'hDEAD_BEEF; #0.1;
      chk("R11 word", cap_word, 31'h7);
      chk("R11 valid", cap_valid, 1);
      // R2 load compares ea, not pc
      ret_load = 1; ret_pc = 32'h80; ret_ea = 32'h10; tick();
      chk("R2 load uses ea (no stop)", state_o, 2);
      ret_ea = 32'h80; tick(); quiet();
      chk("R2 load ea stop", state_o, 0);

      // R8 manual stop collides with delay expiry
      ret_valid = 1; ret_pc = 32'h41; tick(); quiet();
      tick(); tick();
      man_stop = 1; tick(); man_stop = 0;
      chk("R8 stop beats expiry", state_o, 0);
      ret_valid = 1; ret_pc = 32'h41; tick(); quiet();
      man_start = 1; man_stop = 1; tick(); quiet();
      chk("R8 stop over start", state_o, 0);
      man_start = 1; tick(); quiet();
      chk("R8 start cancels/enters", state_o, 2);

      // R9 init beats manual start
      cfg_start_sel = 9; cfg_stop_sel = 8; cfg_dly_mode = 0; cfg_pc_bits = 0;
      cfg_load = 1; man_start = 1; ext_trig = 1; tick(); quiet();
      chk("R9 init idles", state_o, 0);
      // R4 external low start, stop code 8 never fires
      tick();
      chk("R4 ext high no start", state_o, 0);
      ext_trig = 0; tick();
      chk("R4 ext low starts", state_o, 2);
      ext_trig = 1; tick(); tick();
      chk("R4 stop code 8 inert", state_o, 2);
      ret_valid = 1; ret_pc = 32'h6; #0.1;
      chk("R11 pc_bits 0 acts as 1", cap_word, 31'h1);
      quiet();

      // R3 eret start / wait ignored while running (R6) / eret stop
      load_cfg(5, 5, 32'hFFFF, 32'hFFFF, 32'h1, 32'hFF, 0, 0, 31);
      ret_valid = 1; ret_eret = 1; tick(); quiet();
      chk("R3 eret starts regardless of data", state_o, 2);
      load_cfg(6, 5, 0, 0, 0, 0, 0, 0, 31);
      man_start = 1; tick(); quiet();
      ret_valid = 1; ret_wait = 1; tick(); quiet();
      chk("R6 start cond ignored while running", state_o, 2);
      ret_valid = 1; ret_eret = 1; tick(); quiet();
      chk("R3 eret stops", state_o, 0);
      // R5 code 0: only manual
      load_cfg(0, 0, 0, 0, 0, 0, 0, 0, 31);
      ret_valid = 1; ret_eret = 1; ret_wait = 1; ret_halt = 1; exc_valid = 1; tick(); quiet();
      chk("R5 none never fires", state_o, 0);
      man_start = 1; tick(); quiet();
      chk("R5 manual start", state_o, 2);
      // R7 stop delay 2, count 0 acts as none
      load_cfg(7, 4, 0, 0, 32'h3, 32'h7, 2, 2, 31);
      ret_valid = 1; ret_halt = 1; tick(); quiet();
      chk("R7 start undelayed in mode 2", state_o, 2);
      exc_valid = 1; exc_id = 8'hF3; tick(); quiet();
      chk("R2 exc masked hit drains", state_o, 3);
      tick(); tick();
      chk("R7 stop after 2", state_o, 0);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         quiet();
         if ($urandom_range(0, 39) == 0) begin
            cfg_load = 1;
            cfg_start_sel = 4'($urandom_range(0, 11));
            cfg_stop_sel = 4'($urandom_range(0, 11));
            cfg_start_data = $urandom_range(0, 15); cfg_stop_data = $urandom_range(0, 15);
            cfg_start_mask = $urandom_range(0, 3) == 0 ? 32'hFFFF_FFFF : $urandom & 32'hF;
            cfg_stop_mask = $urandom_range(0, 3) == 0 ? 32'hFFFF_FFFF : $urandom & 32'hF;
            cfg_dly_mode = 2'($urandom); cfg_dly_cycles = 16'($urandom_range(0, 5));
            cfg_pc_bits = 5'($urandom);
         end
         man_start = ($urandom_range(0, 29) == 0);
         man_stop = ($urandom_range(0, 29) == 0);
         ret_valid = ($urandom_range(0, 3) != 0);
         ret_pc = ($urandom_range(0, 1) ? ($urandom & 32'hFFFF_FFF0) : 32'h0) | $urandom_range(0, 15);
         ret_ea = $urandom_range(0, 15);
         ret_load = ($urandom_range(0, 5) == 0); ret_store = ($urandom_range(0, 5) == 0);
         exc_valid = ($urandom_range(0, 7) == 0); exc_id = 8'($urandom_range(0, 7));
         ret_eret = ($urandom_range(0, 5) == 0); ret_wait = ($urandom_range(0, 5) == 0);
         ret_halt = ($urandom_range(0, 5) == 0); ext_trig = 1'($urandom);
         tick();
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule